// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Sequencer

This block pairs a host-visible SRAM with a nonvolatile backing array of the same depth and width. In normal running the host reads and writes the SRAM through a chip-select and write-enable pair at one word per cycle, and the backing array is left alone. When the digital power-fail indication rises, the sequencer locks out the host and walks the SRAM from address 0 to the top of the array. It writes each word into the backing array and waits for that array's ready handshake before it moves on to the next address.

When the power-fail indication drops again, the sequencer copies the backing array back into the SRAM, one word per cycle, and then hands control back to the host. The host sees the same contents as before the outage. Two command pulses start a store or a recall on demand. A store that runs past a cycle budget is abandoned and raises a sticky error flag. A recall that is asked for during a store waits its turn and runs as soon as the store ends.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: With `busy` and `pwr_fail` low, a host cycle with `host_cs`=1 and `host_we`=1 writes `host_wdata` at `host_addr`. A cycle with `host_cs`=1 and `host_we`=0 loads the word at `host_addr` into `host_rdata` at the next rising clock edge.
- R2: The backing array receives no write while `busy` is low. Host traffic between two transfers does not change what a later recall returns.
- R3: A rising edge on `pwr_fail` seen while idle drives `busy` high on the next cycle and starts a store.
- R4: A store copies addresses 0 to DEPTH-1 in ascending order. Each backing write is issued only when the backing array is ready, and the next one waits until the array reports ready again.
- R5: If a store has not finished within STORE_TIMEOUT cycles, it is abandoned and `store_err` goes high. `store_err` then stays high until reset.
- R6: A falling edge on `pwr_fail` starts a recall. After the recall, every SRAM word equals the word held in the backing array.
- R7: A one-cycle pulse on `store_req` starts a store, and a one-cycle pulse on `recall_req` starts a recall.
- R8: While `busy` or `pwr_fail` is high, host writes have no effect and `host_rdata` holds its value.
- R9: A recall request that arrives during a store keeps `busy` high and runs right after the store. `busy` stays high while a request is pending.
- R10: After reset, `busy`, `store_err` and `host_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | AW | Host word address |
| host_wdata | input | W | Host write data |
| host_rdata | output | W | Registered host read data |
| pwr_fail | input | 1 | Digital power-fail indication |
| store_req | input | 1 | Store command pulse |
| recall_req | input | 1 | Recall command pulse |
| busy | output | 1 | Transfer running or pending |
| store_err | output | 1 | Sticky store-timeout flag |

## Verification
The bench stores a snapshot and then overwrites the SRAM from the host. A recall must bring back the snapshot: a design that wrote the backing array during normal traffic would return the newer data instead. It also tries host writes and reads while `pwr_fail` is held high after the store has finished. A design that unlocked on `busy` alone would let a write land and show up after the recall. It measures how long `busy` stays high when a recall is queued behind a store, against a store on its own. A design that dropped the queued request would finish about DEPTH cycles early. A second instance with a tiny cycle budget must abandon its store and keep `store_err` high through a later store.

// File: rtl/nvs_pkg.sv
// Shared types for the shadowed SRAM store/recall sequencer.
package nvs_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ISSUE  = 2'd1,
        SQ_WAIT   = 2'd2,
        SQ_RECALL = 2'd3
    } seq_state_t;
endpackage

// File: rtl/shadow_sram.sv
// Host-side SRAM array: one synchronous write port, one combinational read port.
// Assumes the caller muxes host and recall traffic onto the single write port.
module shadow_sram #(
    parameter int W     = 16,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Storage update on write enable.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Combinational read for host register and store path.
    assign rdata = mem[raddr];
endmodule

// File: rtl/nv_backing.sv
// Behavioural backing array: a write takes WR_CYCLES cycles, during which
// ready is low. Reads are combinational. Assumes WR_CYCLES >= 1.
module nv_backing #(
    parameter int W         = 16,
    parameter int DEPTH     = 256,
    parameter int WR_CYCLES = 4,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = $clog2(WR_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata,
    output logic          ready
);
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;

    // Busy countdown started by each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (wr && ready) cnt <= CW'(WR_CYCLES);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    // Cell update on an accepted write.
    always_ff @(posedge clk) begin
        if (wr && ready) mem[waddr] <= wdata;
    end

    assign ready = (cnt == '0);
    assign rdata = mem[raddr];

    // A write always leaves the array not ready for at least one cycle.
    p_write_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !ready);
endmodule

// File: rtl/shadow_seq.sv
// Transfer sequencer: detects power edges and command pulses, walks the
// address pointer for store (handshaked) and recall (one word per cycle),
// queues requests that arrive mid-transfer, and enforces the store budget.
module shadow_seq
    import nvs_pkg::*;
#(
    parameter int DEPTH         = 256,
    parameter int STORE_TIMEOUT = 100000,
    localparam int AW           = $clog2(DEPTH),
    localparam int TW           = $clog2(STORE_TIMEOUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_fail,
    input  logic          store_req,
    input  logic          recall_req,
    input  logic          nv_ready,
    output logic          busy,
    output logic          store_err,
    output logic          nv_wr,
    output logic          rc_we,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [TW-1:0] TLIM = TW'(STORE_TIMEOUT - 1);

    seq_state_t    state;
    logic          pf_q, st_pend, rc_pend;
    logic [TW-1:0] tmo;
    logic          st_trig, rc_trig, tmo_hit;

    assign st_trig = (pwr_fail && !pf_q) || store_req;
    assign rc_trig = (!pwr_fail && pf_q) || recall_req;
    assign tmo_hit = (tmo == TLIM);

    // Power-fail edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) pf_q <= 1'b0;
        else        pf_q <= pwr_fail;
    end

    // Main transfer state machine with request queueing and store budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            ptr       <= '0;
            tmo       <= '0;
            st_pend   <= 1'b0;
            rc_pend   <= 1'b0;
            store_err <= 1'b0;
        end else begin
            if (state != SQ_IDLE && rc_trig)   rc_pend <= 1'b1;
            if (state == SQ_RECALL && st_trig) st_pend <= 1'b1;
            case (state)
                SQ_IDLE: begin
                    ptr <= '0;
                    tmo <= '0;
                    if (st_trig || st_pend) begin
                        state   <= SQ_ISSUE;
                        st_pend <= 1'b0;
                        if (rc_trig) rc_pend <= 1'b1;
                    end else if (rc_trig || rc_pend) begin
                        state   <= SQ_RECALL;
                        rc_pend <= 1'b0;
                    end
                end
                SQ_ISSUE: begin
                    tmo <= tmo + 1'b1;
                    if (tmo_hit) begin
                        store_err <= 1'b1;
                        state     <= SQ_IDLE;
                    end else if (nv_ready) begin
                        state <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    tmo <= tmo + 1'b1;
                    if (nv_ready && ptr == LAST) begin
                        state <= SQ_IDLE;
                    end else if (tmo_hit) begin
                        store_err <= 1'b1;
                        state     <= SQ_IDLE;
                    end else if (nv_ready) begin
                        ptr   <= ptr + 1'b1;
                        state <= SQ_ISSUE;
                    end
                end
                SQ_RECALL: begin
                    ptr <= ptr + 1'b1;
                    if (ptr == LAST) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign nv_wr = (state == SQ_ISSUE) && nv_ready && !tmo_hit;
    assign rc_we = (state == SQ_RECALL);
    assign busy  = (state != SQ_IDLE) || st_pend || rc_pend;

    // Error flag never clears outside reset.
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        store_err |=> store_err);
    // Power loss while idle locks the block on the next cycle.
    p_fail_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && !pf_q && state == SQ_IDLE) |=> busy);
    // Store pointer advances by exactly one between words.
    p_ptr_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_ISSUE && $past(state) == SQ_WAIT) |-> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/nv_shadow_ctrl.sv
// Top: host SRAM, backing array and transfer sequencer. Host access is gated
// off while a transfer runs or is pending, and while power-fail is high.
module nv_shadow_ctrl #(
    parameter int W             = 16,
    parameter int DEPTH         = 256,
    parameter int NV_WR_CYCLES  = 4,
    parameter int STORE_TIMEOUT = 100000,
    localparam int AW           = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cs,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [W-1:0]  host_wdata,
    output logic [W-1:0]  host_rdata,
    input  logic          pwr_fail,
    input  logic          store_req,
    input  logic          recall_req,
    output logic          busy,
    output logic          store_err
);
    logic          locked, host_wr, host_rd;
    logic          nv_wr, nv_ready, rc_we;
    logic [AW-1:0] ptr;
    logic [W-1:0]  sram_q, nv_q;

    assign locked  = busy || pwr_fail;
    assign host_wr = host_cs && host_we && !locked;
    assign host_rd = host_cs && !host_we && !locked;

    shadow_seq #(.DEPTH(DEPTH), .STORE_TIMEOUT(STORE_TIMEOUT)) u_seq (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
        .store_req(store_req), .recall_req(recall_req), .nv_ready(nv_ready),
        .busy(busy), .store_err(store_err), .nv_wr(nv_wr), .rc_we(rc_we),
        .ptr(ptr)
    );

    shadow_sram #(.W(W), .DEPTH(DEPTH)) u_sram (
        .clk(clk),
        .we(host_wr || rc_we),
        .waddr(rc_we ? ptr : host_addr),
        .wdata(rc_we ? nv_q : host_wdata),
        .raddr(busy ? ptr : host_addr),
        .rdata(sram_q)
    );

    nv_backing #(.W(W), .DEPTH(DEPTH), .WR_CYCLES(NV_WR_CYCLES)) u_nv (
        .clk(clk), .rst_n(rst_n), .wr(nv_wr), .waddr(ptr), .wdata(sram_q),
        .raddr(ptr), .rdata(nv_q), .ready(nv_ready)
    );

    // Registered host read data.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= sram_q;
    end

    // Backing array is only written during a transfer.
    p_idle_no_nv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !nv_wr);
    // Host read data frozen while locked out.
    p_host_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(host_rdata));
endmodule

// File: tb/sim_nv_shadow_ctrl.sv
module sim_nv_shadow_ctrl;
    localparam int W = 8, DEPTH = 16, AW = 4, NVC = 3;
    localparam int TMO0 = 1000, TMO1 = 20;

    logic clk = 0, rst_n = 0;
    logic host_cs = 0, host_we = 0;
    logic [AW-1:0] host_addr = '0;
    logic [W-1:0]  host_wdata = '0;
    logic pwr_fail = 0, store_req = 0, recall_req = 0;
    logic store_req1 = 0, recall_req1 = 0, pwr_fail1 = 0;
    logic [W-1:0] rdata, rdata1;
    logic busy, err, busy1, err1;

    int checks = 0, errors = 0;
    logic [W-1:0] sram_exp [DEPTH];
    logic [W-1:0] nv_exp [DEPTH];

    always #10 clk = ~clk;

    nv_shadow_ctrl #(.W(W), .DEPTH(DEPTH), .NV_WR_CYCLES(NVC), .STORE_TIMEOUT(TMO0)) u0 (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata),
        .pwr_fail(pwr_fail), .store_req(store_req), .recall_req(recall_req),
        .busy(busy), .store_err(err));

    nv_shadow_ctrl #(.W(W), .DEPTH(DEPTH), .NV_WR_CYCLES(NVC), .STORE_TIMEOUT(TMO1)) u1 (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata1),
        .pwr_fail(pwr_fail1), .store_req(store_req1), .recall_req(recall_req1),
        .busy(busy1), .store_err(err1));

    function automatic logic [W-1:0] rnd_word();
        return W'($urandom);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        host_cs = 1; host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_cs = 0; host_we = 0;
    endtask

    task automatic host_read(input logic [AW-1:0] a);
        @(negedge clk);
        host_cs = 1; host_we = 0; host_addr = a;
        @(negedge clk);
        host_cs = 0;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1;
        @(negedge clk); sig = 0;
    endtask

    // Waits for busy of u0 (sel=0) or u1 (sel=1) to drop; returns cycles spent.
    task automatic wait_idle(input int sel, output int n);
        n = 0;
        while ((sel == 0 ? busy : busy1) && n < 5000) begin
            @(negedge clk); n++;
        end
        if (n >= 5000) check("wait_idle timeout", 1, 0);
    endtask

    task automatic verify_all(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            host_read(AW'(i));
            check(req, rdata, sram_exp[i]);
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, n_plain, n_queued;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        check("R10 busy", busy, 0);
        check("R10 store_err", err, 0);
        check("R10 rdata", rdata, 0);

        // R1 fill and random read-back
        for (int i = 0; i < DEPTH; i++) begin
            sram_exp[i] = rnd_word();
            host_write(AW'(i), sram_exp[i]);
        end
        for (int k = 0; k < 24; k++) begin
            int a = int'($urandom_range(DEPTH - 1, 0));
            if (k % 3 == 0) begin
                sram_exp[a] = rnd_word();
                host_write(AW'(a), sram_exp[a]);
            end
            host_read(AW'(a));
            check("R1 read-back", rdata, sram_exp[a]);
        end
        host_write(0, 8'hFF); sram_exp[0] = 8'hFF;
        host_write(AW'(DEPTH-1), 8'h00); sram_exp[DEPTH-1] = 8'h00;
        host_read(0);          check("R1 addr 0", rdata, 8'hFF);
        host_read(AW'(DEPTH-1)); check("R1 top addr", rdata, 8'h00);

        // R7 store command, then R2 overwrite, then R7 recall command
        pulse(store_req);
        check("R7 store busy", busy, 1);
        wait_idle(0, n_plain);
        check("R5 no error u0", err, 0);
        for (int i = 0; i < DEPTH; i++) nv_exp[i] = sram_exp[i];
        for (int i = 0; i < DEPTH; i++) begin
            sram_exp[i] = rnd_word();
            host_write(AW'(i), sram_exp[i]);
        end
        host_read(3); check("R1 overwrite", rdata, sram_exp[3]);
        pulse(recall_req);
        check("R7 recall busy", busy, 1);
        wait_idle(0, n);
        for (int i = 0; i < DEPTH; i++) sram_exp[i] = nv_exp[i];
        verify_all("R2 R6 recall returns stored snapshot");

        // R3 power fail store, R8 lockout while held high
        for (int i = 0; i < DEPTH; i++) begin
            sram_exp[i] = rnd_word();
            host_write(AW'(i), sram_exp[i]);
        end
        host_read(7);
        @(negedge clk); pwr_fail = 1;
        @(negedge clk);
        check("R3 busy after power fail", busy, 1);
        host_write(5, ~sram_exp[5]);
        wait_idle(0, n);
        for (int i = 0; i < DEPTH; i++) nv_exp[i] = sram_exp[i];
        host_write(3, ~sram_exp[3]);
        host_read(9);
        check("R8 rdata held while power fail", rdata, sram_exp[7]);
        @(negedge clk); pwr_fail = 0;
        @(negedge clk);
        check("R6 recall on power return", busy, 1);
        wait_idle(0, n);
        host_read(3); check("R8 write during lockout dropped", rdata, nv_exp[3]);
        host_read(5); check("R8 write during store dropped", rdata, nv_exp[5]);
        verify_all("R6 contents after power cycle");

        // R9 recall queued during store: busy lasts longer by a recall
        pulse(store_req);
        repeat (10) @(negedge clk);
        recall_req = 1; @(negedge clk); recall_req = 0;
        wait_idle(0, n_queued);
        n_queued += 11;
        checks++;
        if (n_queued < n_plain + DEPTH) begin
            errors++;
            $display("FAIL R9 queued busy span actual=%0d expected>=%0d", n_queued, n_plain + DEPTH);
        end
        verify_all("R9 contents after queued recall");
        host_write(2, 8'h5A); host_read(2);
        check("R8 host access resumes", rdata, 8'h5A);

        // R4 store duration: each word needs the full write handshake
        checks++;
        if (n_plain < DEPTH * (NVC + 1)) begin
            errors++;
            $display("FAIL R4 store span actual=%0d expected>=%0d", n_plain, DEPTH * (NVC + 1));
        end

        // R5 timeout on the tight-budget instance
        pulse(store_req1);
        wait_idle(1, n);
        check("R5 store_err set", err1, 1);
        checks++;
        if (n > TMO1 + 2) begin
            errors++;
            $display("FAIL R5 abort span actual=%0d expected<=%0d", n, TMO1 + 2);
        end
        pulse(store_req1);
        wait_idle(1, n);
        repeat (5) @(negedge clk);
        check("R5 store_err sticky", err1, 1);
        check("R5 u0 unaffected", err, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule